// File: doc/BRIEF.md
# Shared-Pool Virtual-Channel Input Buffer

This block is the flit store behind one input port of an on-chip router. Its flit slots form one common pool, and every virtual channel draws on that pool as traffic arrives. No virtual channel owns a fixed share. An availability mask marks which slots are empty. For each virtual channel, a linked list of slot indices keeps that channel's flits in arrival order. A flit that arrives tagged with a virtual-channel number goes into the lowest-numbered empty slot, and that slot is added to the tail of its channel's list. A read names a virtual channel. It returns the flit at the head of that channel's list and hands the slot back to the pool.

Each departure produces a credit-return pulse toward the upstream router. The pulse names the virtual channel that was drained. A state table holds one row per virtual channel with its occupancy, its credit count, a six-valued status, an output port and an output virtual channel. The route, virtual-channel and switch allocators outside the block write the last three fields through an update port. A query port reads any row back.

Top module: `shared_vc_buffer`

## Requirements
- R1: After reset, every slot is free (`free_count_o` equals NUM_SLOTS). Every virtual channel has status idle (code 0), occupancy 0, output port 0, output VC 0 and a credit count of NUM_SLOTS. All registered outputs are 0.
- R2: An accepted write stores the flit in the lowest-numbered free slot and lowers `free_count_o` by one from the next cycle on.
- R3: A write that arrives while no slot is free is discarded. `overflow_o` is 1 in the following cycle, and no state changes for the write.
- R4: Flits of one virtual channel are read out in the order they were written, whatever slots they landed in.
- R5: A read of a non-empty virtual channel sets `rd_valid_o` to 1 in the next cycle. In that cycle `rd_flit_o` carries the head flit and `rd_slot_o` carries the slot it occupied. A read of an empty virtual channel leaves `rd_valid_o` at 0 and changes nothing.
- R6: A read and a write may happen in the same cycle. The slot freed by that read is not available to that write, so a write into a full pool is rejected even when a read happens in the same cycle.
- R7: Every accepted read raises `credit_ret_valid_o` for one cycle, with `credit_ret_vc_o` set to the virtual channel that was read, in the same cycle as `rd_valid_o`.
- R8: For each virtual channel, the credit count equals NUM_SLOTS minus that channel's occupancy. The occupancy goes up by one on each accepted write and down by one on each accepted read.
- R9: An update writes the status, output port and output VC of the selected virtual channel. The new values are visible on the query outputs from the next cycle. Status codes: idle 0, waiting 1, route computation 2, VC allocation 3, switch allocation 4, switch traversal 5.
- R10: A virtual channel with flits stored can be read no matter how many flits other virtual channels hold, so no other channel's queue blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Incoming flit valid |
| wr_vc_i | input | VC_W | Virtual channel of the incoming flit |
| wr_flit_i | input | FLIT_W | Incoming flit |
| rd_en_i | input | 1 | Read request |
| rd_vc_i | input | VC_W | Virtual channel to read |
| upd_valid_i | input | 1 | State-table update strobe |
| upd_vc_i | input | VC_W | Virtual channel to update |
| upd_status_i | input | 3 | New status code |
| upd_outport_i | input | PORT_W | New output port |
| upd_outvc_i | input | VC_W | New output virtual channel |
| qry_vc_i | input | VC_W | Virtual channel to query |
| rd_valid_o | output | 1 | Read data valid |
| rd_flit_o | output | FLIT_W | Flit returned by the read |
| rd_slot_o | output | SLOT_W | Slot the returned flit occupied |
| overflow_o | output | 1 | A write was rejected because the pool was full |
| credit_ret_valid_o | output | 1 | Credit return to upstream |
| credit_ret_vc_o | output | VC_W | Virtual channel of the returned credit |
| free_count_o | output | CNT_W | Number of free slots |
| qry_status_o | output | 3 | Status of the queried virtual channel |
| qry_outport_o | output | PORT_W | Output port of the queried virtual channel |
| qry_outvc_o | output | VC_W | Output VC of the queried virtual channel |
| qry_count_o | output | CNT_W | Occupancy of the queried virtual channel |
| qry_credit_o | output | CNT_W | Credit count of the queried virtual channel |

## Verification
The first pattern interleaves writes and reads across three virtual channels. Slots are freed and then refilled in non-sequential positions, so the reported slot numbers separate lowest-free placement from plain sequential placement, and the read order separates per-channel lists from one global FIFO. The second pattern fills the whole pool from one channel and then issues a write with no read, and next a read together with a write. This separates a correct overflow reject from one that reuses a freed slot in the same cycle. Draining a different channel while the full channel still holds seven flits shows that channels do not block each other. The state-table updates and the credit queries are checked against occupancy-derived values.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [2:0] {
        VCS_IDLE    = 3'd0,
        VCS_WAIT    = 3'd1,
        VCS_ROUTE   = 3'd2,
        VCS_VCALLOC = 3'd3,
        VCS_SWALLOC = 3'd4,
        VCS_TRAVERSE = 3'd5
    } vc_status_e;

    localparam int STATUS_W = 3;

    function automatic int unsigned count_ones(input logic [63:0] vec, input int unsigned width);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if (i < width && vec[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/sbuf_free_tracker.sv
module sbuf_free_tracker #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_i,
    input  logic              release_i,
    input  logic [SLOT_W-1:0] release_slot_i,
    output logic [SLOT_W-1:0] alloc_slot_o,
    output logic              any_free_o,
    output logic [CNT_W-1:0]  free_count_o
);
    import sbuf_pkg::*;

    logic [NUM_SLOTS-1:0] free_q;

    // lowest-numbered free slot: scan from the top so the lowest index wins
    always_comb begin
        alloc_slot_o = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_slot_o = SLOT_W'(i);
        end
    end

    assign any_free_o   = |free_q;
    assign free_count_o = CNT_W'(count_ones(64'(free_q), NUM_SLOTS));

    // the read releases a slot that is occupied now, so it never collides
    // with the slot handed out to a write in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= '1;
        end else begin
            if (alloc_i)   free_q[alloc_slot_o]   <= 1'b0;
            if (release_i) free_q[release_slot_i] <= 1'b1;
        end
    end

endmodule

// File: rtl/sbuf_slot_store.sv
module sbuf_slot_store #(
    parameter int NUM_SLOTS = 8,
    parameter int FLIT_W    = 16,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic [FLIT_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0] rslot_i,
    output logic [FLIT_W-1:0] rdata_o
);
    logic [FLIT_W-1:0] mem_q [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[wslot_i] <= wdata_i;
    end

    assign rdata_o = mem_q[rslot_i];

endmodule

// File: rtl/sbuf_vc_table.sv
module sbuf_vc_table #(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_VCS   = 4,
    parameter int NUM_PORTS = 5,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int VC_W   = $clog2(NUM_VCS),
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_i,
    input  logic [VC_W-1:0]           wr_vc_i,
    input  logic [SLOT_W-1:0]         wr_slot_i,
    input  logic                      rd_i,
    input  logic [VC_W-1:0]           rd_vc_i,
    output logic [SLOT_W-1:0]         rd_head_o,
    output logic                      rd_nonempty_o,
    input  logic                      upd_valid_i,
    input  logic [VC_W-1:0]           upd_vc_i,
    input  sbuf_pkg::vc_status_e      upd_status_i,
    input  logic [PORT_W-1:0]         upd_outport_i,
    input  logic [VC_W-1:0]           upd_outvc_i,
    input  logic [VC_W-1:0]           qry_vc_i,
    output sbuf_pkg::vc_status_e      qry_status_o,
    output logic [PORT_W-1:0]         qry_outport_o,
    output logic [VC_W-1:0]           qry_outvc_o,
    output logic [CNT_W-1:0]          qry_count_o,
    output logic [CNT_W-1:0]          qry_credit_o
);
    import sbuf_pkg::*;

    typedef struct packed {
        logic [SLOT_W-1:0] head;
        logic [SLOT_W-1:0] tail;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  credit;
        vc_status_e        status;
        logic [PORT_W-1:0] outport;
        logic [VC_W-1:0]   outvc;
    } vc_entry_t;

    vc_entry_t         ent_q  [NUM_VCS];
    logic [SLOT_W-1:0] link_q [NUM_SLOTS];

    assign rd_head_o     = ent_q[rd_vc_i].head;
    assign rd_nonempty_o = (ent_q[rd_vc_i].count != '0);

    assign qry_status_o  = ent_q[qry_vc_i].status;
    assign qry_outport_o = ent_q[qry_vc_i].outport;
    assign qry_outvc_o   = ent_q[qry_vc_i].outvc;
    assign qry_count_o   = ent_q[qry_vc_i].count;
    assign qry_credit_o  = ent_q[qry_vc_i].credit;

    // append link: only when the target list already holds something
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SLOTS; s++) link_q[s] <= '0;
        end else if (wr_i && ent_q[wr_vc_i].count != '0) begin
            link_q[ent_q[wr_vc_i].tail] <= wr_slot_i;
        end
    end

    generate
        for (genvar v = 0; v < NUM_VCS; v++) begin : g_vc
            logic hit_wr, hit_rd, last_out;
            assign hit_wr   = wr_i && (wr_vc_i == VC_W'(v));
            assign hit_rd   = rd_i && (rd_vc_i == VC_W'(v));
            assign last_out = hit_rd && (ent_q[v].count == CNT_W'(1));

            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q[v].head    <= '0;
                    ent_q[v].tail    <= '0;
                    ent_q[v].count   <= '0;
                    ent_q[v].credit  <= CNT_W'(NUM_SLOTS);
                    ent_q[v].status  <= VCS_IDLE;
                    ent_q[v].outport <= '0;
                    ent_q[v].outvc   <= '0;
                end else begin
                    if (hit_wr && (ent_q[v].count == '0 || last_out)) begin
                        ent_q[v].head <= wr_slot_i;
                    end else if (hit_rd && !last_out) begin
                        ent_q[v].head <= link_q[ent_q[v].head];
                    end
                    if (hit_wr) ent_q[v].tail <= wr_slot_i;
                    if (hit_wr && !hit_rd) begin
                        ent_q[v].count  <= ent_q[v].count + CNT_W'(1);
                        ent_q[v].credit <= ent_q[v].credit - CNT_W'(1);
                    end else if (hit_rd && !hit_wr) begin
                        ent_q[v].count  <= ent_q[v].count - CNT_W'(1);
                        ent_q[v].credit <= ent_q[v].credit + CNT_W'(1);
                    end
                    if (upd_valid_i && upd_vc_i == VC_W'(v)) begin
                        ent_q[v].status  <= upd_status_i;
                        ent_q[v].outport <= upd_outport_i;
                        ent_q[v].outvc   <= upd_outvc_i;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/shared_vc_buffer.sv
module shared_vc_buffer #(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_VCS   = 4,
    parameter int NUM_PORTS = 5,
    parameter int FLIT_W    = 16,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int VC_W   = $clog2(NUM_VCS),
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid_i,
    input  logic [VC_W-1:0]   wr_vc_i,
    input  logic [FLIT_W-1:0] wr_flit_i,
    input  logic              rd_en_i,
    input  logic [VC_W-1:0]   rd_vc_i,
    input  logic              upd_valid_i,
    input  logic [VC_W-1:0]   upd_vc_i,
    input  logic [2:0]        upd_status_i,
    input  logic [PORT_W-1:0] upd_outport_i,
    input  logic [VC_W-1:0]   upd_outvc_i,
    input  logic [VC_W-1:0]   qry_vc_i,
    output logic              rd_valid_o,
    output logic [FLIT_W-1:0] rd_flit_o,
    output logic [SLOT_W-1:0] rd_slot_o,
    output logic              overflow_o,
    output logic              credit_ret_valid_o,
    output logic [VC_W-1:0]   credit_ret_vc_o,
    output logic [CNT_W-1:0]  free_count_o,
    output logic [2:0]        qry_status_o,
    output logic [PORT_W-1:0] qry_outport_o,
    output logic [VC_W-1:0]   qry_outvc_o,
    output logic [CNT_W-1:0]  qry_count_o,
    output logic [CNT_W-1:0]  qry_credit_o
);
    import sbuf_pkg::*;

    logic              any_free, wr_acc, rd_acc, rd_nonempty;
    logic [SLOT_W-1:0] alloc_slot, head_slot;
    logic [FLIT_W-1:0] head_flit;
    vc_status_e        qry_status;

    assign wr_acc = wr_valid_i && any_free;
    assign rd_acc = rd_en_i && rd_nonempty;

    sbuf_free_tracker #(.NUM_SLOTS(NUM_SLOTS)) u_free (
        .clk            (clk),
        .rst            (rst),
        .alloc_i        (wr_acc),
        .release_i      (rd_acc),
        .release_slot_i (head_slot),
        .alloc_slot_o   (alloc_slot),
        .any_free_o     (any_free),
        .free_count_o   (free_count_o)
    );

    sbuf_slot_store #(.NUM_SLOTS(NUM_SLOTS), .FLIT_W(FLIT_W)) u_store (
        .clk     (clk),
        .we_i    (wr_acc),
        .wslot_i (alloc_slot),
        .wdata_i (wr_flit_i),
        .rslot_i (head_slot),
        .rdata_o (head_flit)
    );

    sbuf_vc_table #(.NUM_SLOTS(NUM_SLOTS), .NUM_VCS(NUM_VCS), .NUM_PORTS(NUM_PORTS)) u_tbl (
        .clk           (clk),
        .rst           (rst),
        .wr_i          (wr_acc),
        .wr_vc_i       (wr_vc_i),
        .wr_slot_i     (alloc_slot),
        .rd_i          (rd_acc),
        .rd_vc_i       (rd_vc_i),
        .rd_head_o     (head_slot),
        .rd_nonempty_o (rd_nonempty),
        .upd_valid_i   (upd_valid_i),
        .upd_vc_i      (upd_vc_i),
        .upd_status_i  (vc_status_e'(upd_status_i)),
        .upd_outport_i (upd_outport_i),
        .upd_outvc_i   (upd_outvc_i),
        .qry_vc_i      (qry_vc_i),
        .qry_status_o  (qry_status),
        .qry_outport_o (qry_outport_o),
        .qry_outvc_o   (qry_outvc_o),
        .qry_count_o   (qry_count_o),
        .qry_credit_o  (qry_credit_o)
    );

    assign qry_status_o = qry_status;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o         <= 1'b0;
            rd_flit_o          <= '0;
            rd_slot_o          <= '0;
            overflow_o         <= 1'b0;
            credit_ret_valid_o <= 1'b0;
            credit_ret_vc_o    <= '0;
        end else begin
            rd_valid_o         <= rd_acc;
            overflow_o         <= wr_valid_i && !any_free;
            credit_ret_valid_o <= rd_acc;
            if (rd_acc) begin
                rd_flit_o       <= head_flit;
                rd_slot_o       <= head_slot;
                credit_ret_vc_o <= rd_vc_i;
            end
        end
    end

endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_VCS   = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int VC_W   = $clog2(NUM_VCS),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid_i,
    input logic             rd_en_i,
    input logic [VC_W-1:0]  rd_vc_i,
    input logic             rd_valid_o,
    input logic [SLOT_W-1:0] rd_slot_o,
    input logic             overflow_o,
    input logic             credit_ret_valid_o,
    input logic [VC_W-1:0]  credit_ret_vc_o,
    input logic [CNT_W-1:0] free_count_o,
    input logic [CNT_W-1:0] qry_count_o,
    input logic [CNT_W-1:0] qry_credit_o
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> ($past(wr_valid_i) && $past(free_count_o) == '0));

    p_read_source_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> ($past(rd_en_i) && $past(free_count_o) != CNT_W'(NUM_SLOTS)));

    p_credit_vc_r7: assert property (@(posedge clk) disable iff (rst)
        credit_ret_valid_o |-> (rd_valid_o && credit_ret_vc_o == $past(rd_vc_i)));

    p_idle_free_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid_i && !rd_en_i) |=> $stable(free_count_o));

    p_write_takes_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && !rd_en_i && free_count_o != '0) |=> (free_count_o == $past(free_count_o) - CNT_W'(1)));

    p_credit_sum_r8: assert property (@(posedge clk) disable iff (rst)
        (qry_count_o + qry_credit_o) == CNT_W'(NUM_SLOTS));

    p_slot_range_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> (32'(rd_slot_o) < NUM_SLOTS));

endmodule

bind shared_vc_buffer sbuf_checker #(.NUM_SLOTS(NUM_SLOTS), .NUM_VCS(NUM_VCS)) u_chk (
    .clk                (clk),
    .rst                (rst),
    .wr_valid_i         (wr_valid_i),
    .rd_en_i            (rd_en_i),
    .rd_vc_i            (rd_vc_i),
    .rd_valid_o         (rd_valid_o),
    .rd_slot_o          (rd_slot_o),
    .overflow_o         (overflow_o),
    .credit_ret_valid_o (credit_ret_valid_o),
    .credit_ret_vc_o    (credit_ret_vc_o),
    .free_count_o       (free_count_o),
    .qry_count_o        (qry_count_o),
    .qry_credit_o       (qry_credit_o)
);

// File: tb/shared_vc_buffer_tb_top.sv
module shared_vc_buffer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8, NV = 4, NP = 5, FW = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_valid_i = 0, rd_en_i = 0, upd_valid_i = 0;
    logic [1:0] wr_vc_i = 0, rd_vc_i = 0, upd_vc_i = 0, upd_outvc_i = 0, qry_vc_i = 0;
    logic [15:0] wr_flit_i = 0;
    logic [2:0] upd_status_i = 0, upd_outport_i = 0;
    logic rd_valid_o, overflow_o, credit_ret_valid_o;
    logic [15:0] rd_flit_o;
    logic [2:0] rd_slot_o, qry_status_o, qry_outport_o;
    logic [1:0] credit_ret_vc_o, qry_outvc_o;
    logic [3:0] free_count_o, qry_count_o, qry_credit_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_vc_buffer #(.NUM_SLOTS(NS), .NUM_VCS(NV), .NUM_PORTS(NP), .FLIT_W(FW)) dut_i (.*);

    typedef struct packed {
        logic        wv;
        logic [1:0]  wvc;
        logic [15:0] wd;
        logic        rv;
        logic [1:0]  rvc;
        logic        erv;
        logic [15:0] ed;
        logic [2:0]  eslot;
        logic [3:0]  efree;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd1, 16'h00A1, 1'b0, 2'd0, 1'b0, 16'h0000, 3'd0, 4'd7},
        '{1'b1, 2'd2, 16'h00B1, 1'b0, 2'd0, 1'b0, 16'h0000, 3'd0, 4'd6},
        '{1'b1, 2'd1, 16'h00A2, 1'b0, 2'd0, 1'b0, 16'h0000, 3'd0, 4'd5},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd1, 1'b1, 16'h00A1, 3'd0, 4'd6},
        '{1'b1, 2'd3, 16'h00C1, 1'b1, 2'd2, 1'b1, 16'h00B1, 3'd1, 4'd6},
        '{1'b1, 2'd1, 16'h00A3, 1'b1, 2'd1, 1'b1, 16'h00A2, 3'd2, 4'd6},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd1, 1'b1, 16'h00A3, 3'd1, 4'd7},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd1, 1'b0, 16'h0000, 3'd0, 4'd7},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd3, 1'b1, 16'h00C1, 3'd0, 4'd8}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at the falling edge, let one rising edge pass, sample 1 time unit later
    task automatic step(input logic wv, input logic [1:0] wvc, input logic [15:0] wd,
                        input logic rv, input logic [1:0] rvc);
        @(negedge clk);
        wr_valid_i = wv; wr_vc_i = wvc; wr_flit_i = wd;
        rd_en_i = rv; rd_vc_i = rvc;
        @(posedge clk);
        #1;
        wr_valid_i = 0; rd_en_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1 free_count", int'(free_count_o), NS);
        chk("R1 rd_valid", int'(rd_valid_o), 0);
        chk("R1 overflow", int'(overflow_o), 0);
        for (int v = 0; v < NV; v++) begin
            qry_vc_i = 2'(v);
            #1;
            chk("R1 status idle", int'(qry_status_o), 0);
            chk("R1 count", int'(qry_count_o), 0);
            chk("R1 credit", int'(qry_credit_o), NS);
        end

        // R2, R4, R5, R7: interleaved vector walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].wv, VEC[i].wvc, VEC[i].wd, VEC[i].rv, VEC[i].rvc);
            chk("R5 rd_valid", int'(rd_valid_o), int'(VEC[i].erv));
            chk("R2 free_count", int'(free_count_o), int'(VEC[i].efree));
            chk("R3 no overflow", int'(overflow_o), 0);
            chk("R7 credit_ret", int'(credit_ret_valid_o), int'(VEC[i].erv));
            if (VEC[i].erv) begin
                chk("R4 rd_flit order", int'(rd_flit_o), int'(VEC[i].ed));
                chk("R2 rd_slot lowest free", int'(rd_slot_o), int'(VEC[i].eslot));
                chk("R7 credit_ret_vc", int'(credit_ret_vc_o), int'(VEC[i].rvc));
            end
        end

        // fill the whole pool from VC0
        for (int k = 0; k < NS; k++) step(1, 2'd0, 16'(16'h0100 + k), 0, 0);
        qry_vc_i = 2'd0;
        #1;
        chk("R8 full count", int'(qry_count_o), NS);
        chk("R8 full credit", int'(qry_credit_o), 0);
        chk("R2 free zero", int'(free_count_o), 0);

        // R3: write into a full pool is discarded
        step(1, 2'd0, 16'hDEAD, 0, 0);
        chk("R3 overflow flagged", int'(overflow_o), 1);
        chk("R3 count unchanged", int'(qry_count_o), NS);

        // R6: read and write together, freed slot is not reused this cycle
        step(1, 2'd2, 16'h0222, 1, 2'd0);
        chk("R6 overflow with read", int'(overflow_o), 1);
        chk("R6 rd_flit", int'(rd_flit_o), 16'h0100);
        chk("R6 rd_slot", int'(rd_slot_o), 0);
        chk("R6 free after", int'(free_count_o), 1);
        chk("R7 credit vc0", int'(credit_ret_vc_o), 0);

        step(1, 2'd2, 16'h0222, 0, 0);
        chk("R6 retry accepted", int'(overflow_o), 0);
        chk("R6 free zero again", int'(free_count_o), 0);

        // R10: VC2 drains while VC0 still holds seven flits
        step(0, 2'd0, 16'h0, 1, 2'd2);
        chk("R10 rd_valid", int'(rd_valid_o), 1);
        chk("R10 rd_flit", int'(rd_flit_o), 16'h0222);
        chk("R10 rd_slot", int'(rd_slot_o), 0);
        chk("R7 credit vc2", int'(credit_ret_vc_o), 2);
        qry_vc_i = 2'd0;
        #1;
        chk("R8 vc0 credit", int'(qry_credit_o), 1);

        // R4: remaining VC0 flits in order, dropped flit never appears
        for (int k = 1; k < NS; k++) begin
            step(0, 2'd0, 16'h0, 1, 2'd0);
            chk("R4 vc0 order", int'(rd_flit_o), 16'h0100 + k);
            chk("R4 vc0 slot", int'(rd_slot_o), k);
        end
        step(0, 2'd0, 16'h0, 1, 2'd0);
        chk("R3 discarded flit absent", int'(rd_valid_o), 0);
        chk("R8 vc0 credit restored", int'(qry_credit_o), NS);
        chk("R2 all free", int'(free_count_o), NS);

        // R9: state table update
        @(negedge clk);
        upd_valid_i = 1; upd_vc_i = 2'd2; upd_status_i = 3'd4; upd_outport_i = 3'd3; upd_outvc_i = 2'd1;
        @(posedge clk);
        #1;
        upd_valid_i = 0;
        qry_vc_i = 2'd2;
        #1;
        chk("R9 status", int'(qry_status_o), 4);
        chk("R9 outport", int'(qry_outport_o), 3);
        chk("R9 outvc", int'(qry_outvc_o), 1);
        qry_vc_i = 2'd1;
        #1;
        chk("R9 other vc untouched", int'(qry_status_o), 0);

        finish_run();
    end

endmodule